// File: doc/BRIEF.md
# CAN Timestamp Timer with Compare Actions

This block is the time base of a CAN controller. A free-running 16-bit up counter advances on ticks from a prescaler that divides the peripheral clock by a power of two. The host starts and stops it. Three compare channels watch the counter. When one matches, it can flag an interrupt, reload the counter with a programmable offset, or send a one-cycle request to flush the transmit queue. Two capture registers record the counter value on the start-of-frame and end-of-frame pulses from the CAN side. These values serve as message timestamps and as reference points for network-wide time synchronisation.

The host reaches the block through one 16-bit register port. There are no byte enables. Writes take effect at the clock edge that samples them. Reads decode the address combinationally. The transmit queue lives elsewhere; this block only issues the flush request.

Top module: `can_tstamp_timer`

## Requirements
- R1: After reset every register reads zero, and `irq` and `flush_req` are low.
- R2: While the run bit (CTRL bit 0) is set, the counter adds one on each prescaler tick. While it is clear, the counter holds its value.
- R3: The 3-bit divide field (CTRL bits 3:1) value p gives one tick every 2^p running cycles; values 6 and 7 both divide by 64. The first tick comes on the 2^p-th cycle after the run bit takes effect.
- R4: A CTRL write that changes the divide field restarts the prescaler, so the next tick is a full period later.
- R5: A compare hit for channel i is a tick in a cycle where the counter equals compare register i. A hit sets STAT bit 2+i. The host clears that bit by writing 1 to it; a hit in the same cycle wins over the clear.
- R6: `irq` is high whenever a compare flag is set and the interrupt enable of that channel (ACT bit 3i) is set.
- R7: When a channel with reload enable (ACT bit 3i+1) hits, the counter loads the OFS register instead of incrementing.
- R8: A host write to CNT takes priority over both a reload and an increment in the same cycle.
- R9: When a channel with flush enable (ACT bit 3i+2) hits, `flush_req` is high for exactly the one cycle after the hit. This gives one pulse per pass at any divide ratio.
- R10: `sof` copies the counter into CAP0 and sets STAT bit 0. `eof` copies it into CAP1 and sets STAT bit 1. Both bits are cleared by writing 1, and a capture in the same cycle wins over the clear.
- R11: Register addresses: CTRL 0, CNT 1, OFS 2, ACT 3, compare registers 4 to 6, CAP0 8, CAP1 9, STAT 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| sof | input | 1 | Start-of-frame pulse, triggers capture 0 |
| eof | input | 1 | End-of-frame pulse, triggers capture 1 |
| irq | output | 1 | Compare interrupt request (level) |
| flush_req | output | 1 | One-cycle transmit queue flush request |

## Verification
- **Register writes and captures:** register writes, captures, flag updates and counter reloads appear on `rdata` in the cycle after the edge that samples them. `irq` follows its flag with no added delay.
- **Flush timing:** `flush_req` rises one cycle after the hit cycle.
- **Counting arithmetic:** each run lasts an exact number of cycles between two CTRL writes, so the expected counter value is the start value plus the tick count for that divide ratio.
- **How results are sampled:** the driver queues each expectation in the cycle where it is due. The monitor compares it two time units after the falling edge of that same cycle, clear of the active edge.

// File: rtl/can_tstamp_timer.sv
module can_tstamp_timer #(
  parameter int W    = 16,
  parameter int NCMP = 3,
  parameter int AW   = 4,
  parameter int PW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          sof,
  input  logic          eof,
  output logic          irq,
  output logic          flush_req
);
  localparam int A_CTRL = 0, A_CNT = 1, A_OFS = 2, A_ACT = 3, A_CMP0 = 4;
  localparam int A_CAP0 = 8, A_CAP1 = 9, A_STAT = 10;
  localparam int AEW = 3 * NCMP;

  logic          run;
  logic [2:0]    psel;
  logic [PW-1:0] pre;
  logic [W-1:0]  cnt, ofs, cap0, cap1;
  logic [W-1:0]  cmp [NCMP];
  logic [AEW-1:0] acten;
  logic [1:0]    capf;
  logic [NCMP-1:0] cmpf, hit, irq_en, rel_en, fl_en;

  wire ctrl_wr = wr_en && addr == AW'(A_CTRL);
  wire cnt_wr  = wr_en && addr == AW'(A_CNT);
  wire st_wr   = wr_en && addr == AW'(A_STAT);
  wire psel_chg = ctrl_wr && wdata[3:1] != psel;

  wire [2:0]  shift = (psel > 3'd6) ? 3'd6 : psel;
  wire [PW:0] mask7 = (PW+1)'(((PW+1)'(1) << shift) - (PW+1)'(1));
  wire [PW-1:0] mask = mask7[PW-1:0];
  wire tick = run && ((pre & mask) == mask);

  always_comb begin
    for (int i = 0; i < NCMP; i++) begin
      hit[i]    = tick && cnt == cmp[i];
      irq_en[i] = acten[3*i];
      rel_en[i] = acten[3*i+1];
      fl_en[i]  = acten[3*i+2];
    end
  end

  wire reload = |(hit & rel_en);
  assign irq = |(cmpf & irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      psel <= '0;
      pre <= '0;
      cnt <= '0;
      ofs <= '0;
      acten <= '0;
      cap0 <= '0;
      cap1 <= '0;
      capf <= '0;
      cmpf <= '0;
      flush_req <= 1'b0;
      for (int i = 0; i < NCMP; i++) cmp[i] <= '0;
    end else begin
      if (ctrl_wr) begin
        run  <= wdata[0];
        psel <= wdata[3:1];
      end
      pre <= (!run || psel_chg) ? '0 : pre + 1'b1;

      if (cnt_wr)      cnt <= wdata;
      else if (reload) cnt <= ofs;
      else if (tick)   cnt <= cnt + 1'b1;

      if (wr_en && addr == AW'(A_OFS)) ofs <= wdata;
      if (wr_en && addr == AW'(A_ACT)) acten <= wdata[AEW-1:0];
      for (int i = 0; i < NCMP; i++) begin
        if (wr_en && addr == AW'(A_CMP0 + i)) cmp[i] <= wdata;
        cmpf[i] <= hit[i] | (cmpf[i] & ~(st_wr & wdata[2+i]));
      end

      if (sof) cap0 <= cnt;
      if (eof) cap1 <= cnt;
      capf[0] <= sof | (capf[0] & ~(st_wr & wdata[0]));
      capf[1] <= eof | (capf[1] & ~(st_wr & wdata[1]));

      flush_req <= |(hit & fl_en);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_CTRL): rdata = W'({psel, run});
      AW'(A_CNT):  rdata = cnt;
      AW'(A_OFS):  rdata = ofs;
      AW'(A_ACT):  rdata = W'(acten);
      AW'(A_CAP0): rdata = cap0;
      AW'(A_CAP1): rdata = cap1;
      AW'(A_STAT): rdata = W'({cmpf, capf});
      default: begin
        for (int i = 0; i < NCMP; i++)
          if (addr == AW'(A_CMP0 + i)) rdata = cmp[i];
      end
    endcase
  end
endmodule

// File: rtl/can_tstamp_timer_chk.sv
module can_tstamp_timer_chk #(
  parameter int W    = 16,
  parameter int NCMP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [2:0]      psel,
  input logic            tick,
  input logic            reload,
  input logic            cnt_wr,
  input logic [W-1:0]    wdata,
  input logic [W-1:0]    cnt,
  input logic [W-1:0]    ofs,
  input logic            sof,
  input logic [W-1:0]    cap0,
  input logic [1:0]      capf,
  input logic [NCMP-1:0] cmpf,
  input logic            irq,
  input logic            flush_req
);
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && !cnt_wr) |=> cnt == W'($past(cnt) + 1'b1));

  p_div_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && psel == 3'd0) |-> tick);

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmpf != '0);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !cnt_wr) |=> cnt == $past(ofs));

  p_host_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));

  p_flush_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !flush_req);

  p_capture_sof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (cap0 == $past(cnt) && capf[0]));
endmodule

bind can_tstamp_timer can_tstamp_timer_chk #(.W(W), .NCMP(NCMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .psel(psel), .tick(tick),
  .reload(reload), .cnt_wr(cnt_wr), .wdata(wdata), .cnt(cnt), .ofs(ofs),
  .sof(sof), .cap0(cap0), .capf(capf), .cmpf(cmpf), .irq(irq),
  .flush_req(flush_req)
);

// File: tb/sim_can_tstamp_timer.sv
module sim_can_tstamp_timer;
  logic clk = 0, rst_n = 0, wr_en = 0, sof = 0, eof = 0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, flush_req;

  can_tstamp_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sof(sof), .eof(eof), .irq(irq),
    .flush_req(flush_req));

  always #5 clk = ~clk;

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int nchk = 0, nfail = 0, flush_cnt = 0;
  bit done = 0;

  localparam logic [3:0] CTRL = 0, CNT = 1, OFS = 2, ACT = 3, CMP0 = 4,
    CMP1 = 5, CMP2 = 6, CAP0 = 8, CAP1 = 9, STAT = 10;

  always @(negedge clk) if (flush_req) flush_cnt++;

  initial forever begin
    @(negedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {15'd0, irq};
        2: act = {15'd0, flush_req};
        default: act = 16'(flush_cnt);
      endcase
      nchk++;
      if (act !== it.exp) begin
        nfail++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d,
                      input logic s = 0, input logic e = 0);
    @(negedge clk); #1;
    wr_en = w; addr = a; wdata = d; sof = s; eof = e;
  endtask

  task automatic expect_now(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    step(0, a, 16'h0);
    expect_now(0, exp, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 4'hF, 16'h0);
  endtask

  task automatic run_n(input int p, input int n);
    wr(CTRL, 16'((p << 1) | 1));
    idle(n - 1);
    wr(CTRL, 16'(p << 1));
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(CTRL, 16'h0000, "R1 ctrl");
    rd(CNT, 16'h0000, "R1 cnt");
    rd(STAT, 16'h0000, "R1 stat");
    expect_now(1, 16'h0, "R1 irq");
    expect_now(2, 16'h0, "R1 flush");
    // R2 load, hold, run
    wr(CNT, 16'h0100);
    rd(CNT, 16'h0100, "R8 host load");
    idle(4);
    rd(CNT, 16'h0100, "R2 hold stopped");
    run_n(0, 5);
    rd(CNT, 16'h0105, "R2 run div1");
    // R3 divide ratios
    run_n(2, 10);
    rd(CNT, 16'h0107, "R3 div4");
    run_n(6, 130);
    rd(CNT, 16'h0109, "R3 div64");
    run_n(7, 64);
    rd(CNT, 16'h010A, "R3 field7 div64");
    // R4 restart on field change
    wr(CTRL, 16'((3 << 1) | 1));
    idle(6);
    wr(CTRL, 16'((2 << 1) | 1));
    idle(2);
    wr(CTRL, 16'(2 << 1));
    rd(CNT, 16'h010A, "R4 prescaler restart");
    // R5/R6 compare flags and irq
    wr(CMP0, 16'h010D);
    wr(ACT, 16'h0001);
    run_n(0, 5);
    rd(STAT, 16'h0004, "R5 ch0 flag");
    expect_now(1, 16'h1, "R6 irq on");
    rd(CNT, 16'h010F, "R2 count past match");
    wr(CMP1, 16'h0110);
    run_n(0, 2);
    rd(STAT, 16'h000C, "R5 ch1 flag");
    wr(STAT, 16'h0004);
    rd(STAT, 16'h0008, "R5 w1c ch0");
    expect_now(1, 16'h0, "R6 irq off when enable clear");
    wr(STAT, 16'h0008);
    rd(STAT, 16'h0000, "R5 w1c ch1");
    // R7 reload
    wr(OFS, 16'h0020);
    wr(CMP1, 16'h0113);
    wr(ACT, 16'h0010);
    run_n(0, 5);
    rd(CNT, 16'h0022, "R7 reload offset");
    wr(STAT, 16'h0008);
    // R8 host write beats reload
    wr(CMP1, 16'h0023);
    wr(CTRL, 16'h0001);
    idle(1);
    wr(CNT, 16'h0500);
    wr(CTRL, 16'h0000);
    rd(CNT, 16'h0501, "R8 host beats reload");
    wr(STAT, 16'h0008);
    wr(ACT, 16'h0000);
    // R9 flush pulse
    wr(CMP2, 16'h0503);
    wr(ACT, 16'h0100);
    wr(CTRL, 16'h0001);
    idle(3);
    expect_now(2, 16'h0, "R9 no flush in hit cycle");
    idle(1);
    expect_now(2, 16'h1, "R9 flush after hit");
    wr(CTRL, 16'h0000);
    expect_now(2, 16'h0, "R9 flush one cycle");
    rd(CNT, 16'h0506, "R2 count across flush");
    wr(CMP2, 16'h0507);
    @(negedge clk); #1;
    snap = flush_cnt;
    run_n(2, 12);
    rd(CNT, 16'h0509, "R3 div4 across match");
    expect_now(3, 16'(snap + 1), "R9 single flush at div4");
    wr(STAT, 16'h0010);
    wr(ACT, 16'h0000);
    // R10 captures
    step(0, 4'hF, 16'h0, 1, 0);
    rd(CAP0, 16'h0509, "R10 cap0 value");
    rd(STAT, 16'h0001, "R10 sof flag");
    wr(CNT, 16'h0777);
    step(0, 4'hF, 16'h0, 0, 1);
    rd(CAP1, 16'h0777, "R10 cap1 value");
    rd(STAT, 16'h0003, "R10 eof flag");
    step(1, STAT, 16'h0001, 1, 0);
    rd(STAT, 16'h0003, "R10 capture beats clear");
    rd(CAP0, 16'h0777, "R10 cap0 recapture");
    wr(STAT, 16'h0003);
    rd(STAT, 16'h0000, "R10 w1c both");
    // R11 offset and compare readback
    rd(OFS, 16'h0020, "R11 ofs addr");
    rd(CMP2, 16'h0507, "R11 cmp2 addr");
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule